// File: doc/BRIEF.md
# Microprogram Sequencer with Flag and Opcode Branching

This block is the control unit of a microcoded data path. It holds a writable control store of 512 words of 36 bits and two registers. One is the 9-bit microprogram counter (MPC). The other is the 36-bit microinstruction register (MIR), whose bits drive the data path for the current cycle. Each cycle the MIR is split into six fields:

- a successor address,
- a three-bit branch-control field,
- an ALU/shifter control byte,
- nine register write enables,
- three memory-operation bits,
- a four-bit bus-source code, which the block decodes into one-hot bus enables.

No counter increments the MPC: every microinstruction names its own successor. Two mechanisms make the successor conditional. The negative and zero flags from the data path can be ORed into the top address bit. The 8-bit byte from the instruction-byte register (MBR) can be ORed into the low eight address bits, which gives a 256-way dispatch on an opcode. The control store is filled through a load port while the sequencer is held in reset, so no file is needed to set up the microprogram.

Top module: `ucode_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, MPC becomes 0 and MIR is loaded with control-store word 0. Reset is synchronous and active low.
- R2: The MIR layout is:
  - [35:27] successor address
  - [26:24] branch control {dispatch, jump-on-negative, jump-on-zero}
  - [23:16] ALU/shifter control, output on `alu_ctl`
  - [15:7] write enables
  - [6:4] memory-operation bits, output on `mem_ctl`
  - [3:0] bus-source code
- R3: When the branch-control field is 000, the next MPC equals the successor address, unchanged.
- R4: Next MPC bit 8 = successor[8] OR (jump-on-zero AND `flag_z`) OR (jump-on-negative AND `flag_n`). The flags are sampled at the same edge as the MPC update.
- R5: When the dispatch bit is set, next MPC bits [7:0] = successor[7:0] OR `mbr`. When it is clear, they equal successor[7:0].
- R6: Bus-source codes 0 to 8 each assert exactly one bit of `b_en`: the bit whose index equals the code. The sources in code order are MDR, PC, MBR, MBRU, SP, LV, CPP, TOS, OPC.
- R7: Bus-source codes 9 to 15 leave `b_en` all zero.
- R8: `c_wr` carries MIR[15:7] bit for bit, so any combination of the nine write enables can be active in one cycle.
- R9: After each rising edge, MIR holds the control-store word at the new MPC, and the outputs reflect that word during the following cycle.
- R10: A write on the load port (`ld_en`, `ld_addr`, `ld_data`) changes the control store only when `rst_n` is low; while running, the port is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also opens the load port |
| ld_en | input | 1 | Control-store write strobe |
| ld_addr | input | 9 | Control-store write address |
| ld_data | input | 36 | Control-store write word |
| flag_n | input | 1 | Negative flag from the data path |
| flag_z | input | 1 | Zero flag from the data path |
| mbr | input | 8 | Instruction byte used for dispatch |
| mpc | output | 9 | Current microprogram counter |
| alu_ctl | output | 8 | ALU and shifter control |
| c_wr | output | 9 | Register write enables |
| mem_ctl | output | 3 | Memory-operation bits |
| b_en | output | 9 | One-hot bus-source enables |

## Verification
The bench walks long microprogram chains whose words cover every branch-control combination and every bus-source code. It drives the flags and the dispatch byte with pseudo-random values, which exercises the corners below.

- **Flag ORed into the wrong bit, or overriding instead of ORing.** A design that did this would send the program to the wrong half of the store when successor[8] is already set.
- **Dispatch byte replacing the successor bits instead of ORing with them.** This would lose successor bits that are set in the low byte.
- **Decoder that aliases the unused codes 9 to 15.** It would drive a register onto the bus when no source is selected.
- **Load port not blocked while running.** Writes are attempted on every cycle of the run; a design that accepted them would corrupt the microprogram mid-run and show a changed word 0 at the next reset.

// File: rtl/ucode_pkg.sv
package ucode_pkg;
    // Bit positions inside the three-bit branch-control field.
    localparam int JAM_W        = 3;
    localparam int JAM_Z_BIT    = 0;
    localparam int JAM_N_BIT    = 1;
    localparam int JAM_DISP_BIT = 2;

    // Bus-source codes; the decoder output bit index equals the code.
    typedef enum logic [3:0] {
        BSRC_MDR  = 4'd0,
        BSRC_PC   = 4'd1,
        BSRC_MBR  = 4'd2,
        BSRC_MBRU = 4'd3,
        BSRC_SP   = 4'd4,
        BSRC_LV   = 4'd5,
        BSRC_CPP  = 4'd6,
        BSRC_TOS  = 4'd7,
        BSRC_OPC  = 4'd8
    } bsrc_e;
endpackage

// File: rtl/ucode_store.sv
module ucode_store #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/ucode_next.sv
module ucode_next import ucode_pkg::*; #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0] succ,
    input  logic [JAM_W-1:0]  jam,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic [ADDR_W-2:0] mbr,
    output logic [ADDR_W-1:0] mpc_nxt
);
    logic              hi_bit;
    logic [ADDR_W-2:0] lo_bits;

    always_comb begin
        hi_bit  = succ[ADDR_W-1]
                | (jam[JAM_N_BIT] & flag_n)
                | (jam[JAM_Z_BIT] & flag_z);
        lo_bits = succ[ADDR_W-2:0];
        if (jam[JAM_DISP_BIT]) begin
            lo_bits = lo_bits | mbr;
        end
        mpc_nxt = {hi_bit, lo_bits};
    end
endmodule

// File: rtl/ucode_bdec.sv
module ucode_bdec #(
    parameter int B_W    = 4,
    parameter int BREG_N = 9
) (
    input  logic [B_W-1:0]    code,
    output logic [BREG_N-1:0] en
);
    generate
        for (genvar i = 0; i < BREG_N; i++) begin : g_src
            assign en[i] = (code == B_W'(i));
        end
    endgenerate
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer import ucode_pkg::*; #(
    parameter int ADDR_W = 9,
    parameter int ALU_W  = 8,
    parameter int C_W    = 9,
    parameter int MEM_W  = 3,
    parameter int B_W    = 4,
    parameter int BREG_N = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [ADDR_W+JAM_W+ALU_W+C_W+MEM_W+B_W-1:0] ld_data,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic [ADDR_W-2:0] mbr,
    output logic [ADDR_W-1:0] mpc,
    output logic [ALU_W-1:0]  alu_ctl,
    output logic [C_W-1:0]    c_wr,
    output logic [MEM_W-1:0]  mem_ctl,
    output logic [BREG_N-1:0] b_en
);
    localparam int WORD_W = ADDR_W + JAM_W + ALU_W + C_W + MEM_W + B_W;
    localparam int B_LO   = 0;
    localparam int MEM_LO = B_LO + B_W;
    localparam int C_LO   = MEM_LO + MEM_W;
    localparam int ALU_LO = C_LO + C_W;
    localparam int JAM_LO = ALU_LO + ALU_W;
    localparam int NA_LO  = JAM_LO + JAM_W;

    typedef struct packed {
        logic [ADDR_W-1:0] mpc;
        logic [WORD_W-1:0] mir;
    } seq_t;

    seq_t              st_d, st_q;
    logic [WORD_W-1:0] mir_cur;
    logic [WORD_W-1:0] rd_word;
    logic [ADDR_W-1:0] nxt_addr;
    logic [ADDR_W-1:0] mpc_d;
    logic              store_we;

    assign mir_cur  = st_q.mir;
    assign store_we = ld_en & ~rst_n;

    ucode_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (mpc_d),
        .rdata (rd_word)
    );

    ucode_next #(.ADDR_W(ADDR_W)) u_next (
        .succ    (mir_cur[NA_LO +: ADDR_W]),
        .jam     (mir_cur[JAM_LO +: JAM_W]),
        .flag_n  (flag_n),
        .flag_z  (flag_z),
        .mbr     (mbr),
        .mpc_nxt (nxt_addr)
    );

    ucode_bdec #(.B_W(B_W), .BREG_N(BREG_N)) u_bdec (
        .code (mir_cur[B_LO +: B_W]),
        .en   (b_en)
    );

    assign mpc_d = rst_n ? nxt_addr : '0;

    always_comb begin
        st_d.mpc = mpc_d;
        st_d.mir = rd_word;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mpc     = st_q.mpc;
    assign alu_ctl = mir_cur[ALU_LO +: ALU_W];
    assign c_wr    = mir_cur[C_LO +: C_W];
    assign mem_ctl = mir_cur[MEM_LO +: MEM_W];
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 36,
    parameter int B_W    = 4,
    parameter int BREG_N = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mpc,
    input logic [WORD_W-1:0] mir,
    input logic [BREG_N-1:0] b_en,
    input logic              flag_n,
    input logic              flag_z,
    input logic [ADDR_W-2:0] mbr
);
    localparam int NA_HI  = WORD_W - 1;
    localparam int NA_LO  = WORD_W - ADDR_W;
    localparam int DISP   = NA_LO - 1;
    localparam int JN     = NA_LO - 2;
    localparam int JZ     = NA_LO - 3;

    AST_RESET_HOME: assert property (@(posedge clk)
        !rst_n |=> (mpc == '0)); // R1

    AST_FLAG_HI: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mpc[ADDR_W-1] == ($past(mir[NA_HI])
            | ($past(mir[JN]) & $past(flag_n))
            | ($past(mir[JZ]) & $past(flag_z))))); // R4

    AST_PLAIN_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(mir[DISP])) |->
            (mpc[ADDR_W-2:0] == $past(mir[NA_HI-1:NA_LO]))); // R3

    AST_DISPATCH_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mir[DISP])) |->
            (mpc[ADDR_W-2:0] == ($past(mir[NA_HI-1:NA_LO]) | $past(mbr)))); // R5

    AST_BUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $onehot0(b_en)); // R6

    AST_BUS_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (int'(mir[B_W-1:0]) >= BREG_N)) |-> (b_en == '0)); // R7
endmodule

bind ucode_sequencer ucode_seq_chk #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W),
    .B_W    (B_W),
    .BREG_N (BREG_N)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mpc    (mpc),
    .mir    (mir_cur),
    .b_en   (b_en),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .mbr    (mbr)
);

// File: tb/tb_ucode_sequencer.sv
`timescale 1ns/1ps
module tb_ucode_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [8:0]  ld_addr = '0;
    logic [35:0] ld_data = '0;
    logic        flag_n = 1'b0;
    logic        flag_z = 1'b0;
    logic [7:0]  mbr = '0;
    logic [8:0]  mpc;
    logic [7:0]  alu_ctl;
    logic [8:0]  c_wr;
    logic [2:0]  mem_ctl;
    logic [8:0]  b_en;

    int checks = 0;
    int errors = 0;
    logic [35:0] model [512];
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    ucode_sequencer dut (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .flag_n(flag_n), .flag_z(flag_z), .mbr(mbr), .mpc(mpc), .alu_ctl(alu_ctl),
        .c_wr(c_wr), .mem_ctl(mem_ctl), .b_en(b_en)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [35:0] gen(input int a, input int seed);
        logic [8:0] na;
        logic [2:0] jam;
        logic [7:0] alu;
        logic [8:0] cw;
        logic [2:0] mem;
        logic [3:0] b;
        na  = 9'((a * 97 + 13 + seed * 211) % 512);
        jam = 3'((a + seed) % 8);
        alu = 8'((a * 3) ^ (seed * 77));
        cw  = 9'((a * 5 + seed * 31) % 512);
        mem = 3'(a % 8);
        b   = 4'((a / 3 + seed) % 16);
        return {na, jam, alu, cw, mem, b};
    endfunction

    function automatic logic [8:0] bexp(input logic [3:0] code);
        return (code < 4'd9) ? (9'd1 << code) : 9'd0;
    endfunction

    function automatic logic [8:0] next_of(input logic [35:0] w, input logic n,
                                           input logic z, input logic [7:0] m);
        logic hi;
        logic [7:0] lo;
        hi = w[35] | (w[25] & n) | (w[24] & z);
        lo = w[26] ? (w[34:27] | m) : w[34:27];
        return {hi, lo};
    endfunction

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic check_word(input logic [35:0] w, input string tag);
        chk(alu_ctl == w[23:16], "R2", {tag, " alu_ctl"}, 36'(alu_ctl), 36'(w[23:16]));
        chk(mem_ctl == w[6:4], "R2", {tag, " mem_ctl"}, 36'(mem_ctl), 36'(w[6:4]));
        chk(c_wr == w[15:7], "R8", {tag, " c_wr"}, 36'(c_wr), 36'(w[15:7]));
        if (w[3:0] < 4'd9)
            chk(b_en == bexp(w[3:0]), "R6", {tag, " b_en"}, 36'(b_en), 36'(bexp(w[3:0])));
        else
            chk(b_en == 9'd0, "R7", {tag, " b_en none"}, 36'(b_en), 36'd0);
    endtask

    task automatic run_seed(input int seed, input int cycles);
        logic [8:0] mexp;
        logic [2:0] pjam;
        rst_n = 1'b0;
        for (int a = 0; a < 512; a++) begin
            model[a] = gen(a, seed);
            ld_en = 1'b1; ld_addr = 9'(a); ld_data = model[a];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // R1: reset state, MIR holds word 0
        chk(mpc == 9'd0, "R1", "reset mpc", 36'(mpc), 36'd0);
        check_word(model[0], "R1 reset word0");
        // release reset; compute first successor from word 0
        lfsr = step(lfsr);
        flag_n = lfsr[0]; flag_z = lfsr[1]; mbr = lfsr[9:2];
        mexp = next_of(model[0], flag_n, flag_z, mbr);
        pjam = model[0][26:24];
        rst_n = 1'b1;
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            if (pjam == 3'b000)
                chk(mpc == mexp, "R3", "plain successor", 36'(mpc), 36'(mexp));
            else if (pjam[2])
                chk(mpc == mexp, "R5", "dispatch successor", 36'(mpc), 36'(mexp));
            else
                chk(mpc == mexp, "R4", "flag successor", 36'(mpc), 36'(mexp));
            check_word(model[mexp], "R9 run");
            lfsr = step(lfsr);
            flag_n = lfsr[0]; flag_z = lfsr[1]; mbr = lfsr[9:2];
            // R10: write attempts while running must be ignored
            ld_en = lfsr[11]; ld_addr = lfsr[3] ? 9'd0 : 9'(lfsr[15:7]);
            ld_data = ~model[ld_addr];
            pjam = model[mexp][26:24];
            mexp = next_of(model[mexp], flag_n, flag_z, mbr);
        end
        ld_en = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk(mpc == 9'd0, "R1", "re-reset mpc", 36'(mpc), 36'd0);
        check_word(model[0], "R10 word0 after run");
    endtask

    initial begin
        #(5.0 * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        run_seed(0, 2000);
        run_seed(1, 2000);
        run_seed(5, 1500);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule